// File: doc/BRIEF.md
# Mode-Selected 4-bit Arithmetic Logic Unit

This block is a small arithmetic logic unit for a datapath slice. It takes two operands, a mode bit and a four-bit function code. With the mode bit high it works bitwise. With the mode bit low it does arithmetic. Only the lower eight function codes are defined, and each one has a meaning in both modes. The upper eight codes are reserved and give a zero result.

Addition, increment and pass-through share a ripple chain of full adders. Subtraction and decrement use their own ripple chain of full subtractors, each of which forms x - y - borrow_in. Subtraction is not done by adding a complement. A final selector picks which unit drives the result. It also routes out a carry or borrow flag when the chosen function has one. By default the result and flag pass through one output register, which sets the timing boundary. A parameter can remove that register.

Top module: `mode_alu4`

## Requirements
- R1: With mode_logic=1, func_sel 0000 gives ~A, 0001 gives ~B, 0010 gives A&B, 0011 gives A|B, 0100 gives ~(A&B) and 0111 gives A^B. In all of these carry_out is 0.
- R2: The pass-through codes give the operand unchanged with carry_out 0. In arithmetic mode 0000 passes A and 0001 passes B. In logic mode 0101 passes A and 0110 passes B.
- R3: With mode_logic=0, code 0010 gives (A+B) mod 16. carry_out is the carry out of the top adder stage, which is bit 4 of the true sum.
- R4: With mode_logic=0, code 0011 gives (A-B) mod 16. carry_out is the final borrow, which is 1 exactly when A < B.
- R5: With mode_logic=0, code 0100 gives A+1 and code 0110 gives B+1, both mod 16. carry_out is 1 only when the operand is 1111, in which case the result is 0000.
- R6: With mode_logic=0, code 0101 gives A-1 and code 0111 gives B-1, both mod 16. carry_out is 1 only when the operand is 0000, in which case the result is 1111.
- R7: Any func_sel with bit 3 set gives result 0000 and carry_out 0, in either mode.
- R8: With the default REG_OUT=1, the result and carry_out show the inputs from the previous rising clock edge. An active-low reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset for the output register |
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| mode_logic | input | 1 | 1 selects bitwise functions, 0 selects arithmetic |
| func_sel | input | 4 | Function code; bit 3 set is reserved |
| result | output | 4 | Function result |
| carry_out | output | 1 | Adder carry or subtractor borrow, otherwise 0 |

## Verification
The bench drives every operand pair through every function code in both modes, so every wrap point is covered. These include 1111+1, 0000-1 and both operand orders of A<B and A>B in subtraction. If the design confused carry with borrow, or used a complement-and-add, the flag would be inverted on subtraction. If a routing multiplexer were wrong, a function would be applied to the wrong operand, for example B+1 computed from A. If the reserved-code decode were wrong, a nonzero value would leak out. If the output register were skewed, results would land one cycle off from the reference.

// File: rtl/mode_alu4_pkg.sv
package mode_alu4_pkg;

   localparam int unsigned FN_W = 4;

   // lower three bits of the function code; bit 3 is the reserved flag
   typedef enum logic [2:0] {
      FN_C0 = 3'b000,
      FN_C1 = 3'b001,
      FN_C2 = 3'b010,
      FN_C3 = 3'b011,
      FN_C4 = 3'b100,
      FN_C5 = 3'b101,
      FN_C6 = 3'b110,
      FN_C7 = 3'b111
   } fn_code_t;

   typedef enum logic [1:0] {
      SRC_ZERO  = 2'b00,
      SRC_LOGIC = 2'b01,
      SRC_ADD   = 2'b10,
      SRC_SUB   = 2'b11
   } out_src_t;

   // operand routing into one ripple chain
   typedef struct packed {
      logic x_from_b;   // chain x operand is B instead of A
      logic y_is_b;     // chain y operand is B instead of zero
      logic in_bit;     // carry-in or borrow-in
   } chain_route_t;

endpackage

// File: rtl/mode_alu4_adder_chain.sv
module mode_alu4_adder_chain #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   logic [WIDTH:0] carry;

   assign carry[0] = cin_i;

   for (genvar g = 0; g < WIDTH; g++) begin : g_fa
      assign sum_o[g]    = x_i[g] ^ y_i[g] ^ carry[g];
      assign carry[g+1]  = (x_i[g] & y_i[g]) | (x_i[g] & carry[g]) | (y_i[g] & carry[g]);
   end

   assign cout_o = carry[WIDTH];
endmodule

// File: rtl/mode_alu4_subtractor_chain.sv
module mode_alu4_subtractor_chain #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             bin_i,
   output logic [WIDTH-1:0] diff_o,
   output logic             bout_o
);
   logic [WIDTH:0] borrow;

   assign borrow[0] = bin_i;

   for (genvar g = 0; g < WIDTH; g++) begin : g_fs
      assign diff_o[g]    = x_i[g] ^ y_i[g] ^ borrow[g];
      assign borrow[g+1]  = (~x_i[g] & y_i[g]) | (~x_i[g] & borrow[g]) | (y_i[g] & borrow[g]);
   end

   assign bout_o = borrow[WIDTH];
endmodule

// File: rtl/mode_alu4_logic_unit.sv
module mode_alu4_logic_unit
   import mode_alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  fn_code_t         code_i,
   output logic [WIDTH-1:0] f_o
);
   always_comb begin
      unique case (code_i)
         FN_C0:   f_o = ~a_i;
         FN_C1:   f_o = ~b_i;
         FN_C2:   f_o = a_i & b_i;
         FN_C3:   f_o = a_i | b_i;
         FN_C4:   f_o = ~(a_i & b_i);
         FN_C5:   f_o = a_i;
         FN_C6:   f_o = b_i;
         FN_C7:   f_o = a_i ^ b_i;
         default: f_o = '0;
      endcase
   end
endmodule

// File: rtl/mode_alu4_out_stage.sv
module mode_alu4_out_stage #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] f_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] f_o,
   output logic             c_o
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_o <= '0;
            c_o <= 1'b0;
         end else begin
            f_o <= f_i;
            c_o <= c_i;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign f_o = f_i;
      assign c_o = c_i;
   end
endmodule

// File: rtl/mode_alu4.sv
module mode_alu4
   import mode_alu4_pkg::*;
#(
   parameter int unsigned WIDTH   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             mode_logic,
   input  logic [FN_W-1:0]  func_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("mode_alu4: WIDTH must be at least 2");
   end

   fn_code_t     code;
   logic         reserved;
   chain_route_t add_rt, sub_rt;
   out_src_t     src;

   logic [WIDTH-1:0] add_x, add_y, add_s;
   logic [WIDTH-1:0] sub_x, sub_y, sub_d;
   logic             add_c, sub_b;
   logic [WIDTH-1:0] logic_f;
   logic [WIDTH-1:0] f_next;
   logic             c_next;

   assign code     = fn_code_t'(func_sel[2:0]);
   assign reserved = func_sel[FN_W-1];

   // function decode: which unit drives and how each chain is fed
   always_comb begin
      add_rt = '{x_from_b: 1'b0, y_is_b: 1'b0, in_bit: 1'b0};
      sub_rt = '{x_from_b: 1'b0, y_is_b: 1'b0, in_bit: 1'b0};
      src    = SRC_ZERO;
      if (reserved) begin
         src = SRC_ZERO;
      end else if (mode_logic) begin
         src = SRC_LOGIC;
      end else begin
         unique case (code)
            FN_C0: begin src = SRC_ADD; end
            FN_C1: begin src = SRC_ADD; add_rt.x_from_b = 1'b1; end
            FN_C2: begin src = SRC_ADD; add_rt.y_is_b = 1'b1; end
            FN_C3: begin src = SRC_SUB; sub_rt.y_is_b = 1'b1; end
            FN_C4: begin src = SRC_ADD; add_rt.in_bit = 1'b1; end
            FN_C5: begin src = SRC_SUB; sub_rt.in_bit = 1'b1; end
            FN_C6: begin src = SRC_ADD; add_rt.x_from_b = 1'b1; add_rt.in_bit = 1'b1; end
            FN_C7: begin src = SRC_SUB; sub_rt.x_from_b = 1'b1; sub_rt.in_bit = 1'b1; end
            default: src = SRC_ZERO;
         endcase
      end
   end

   assign add_x = add_rt.x_from_b ? op_b : op_a;
   assign add_y = add_rt.y_is_b   ? op_b : '0;
   assign sub_x = sub_rt.x_from_b ? op_b : op_a;
   assign sub_y = sub_rt.y_is_b   ? op_b : '0;

   mode_alu4_adder_chain #(.WIDTH(WIDTH)) u_add (
      .x_i(add_x), .y_i(add_y), .cin_i(add_rt.in_bit),
      .sum_o(add_s), .cout_o(add_c)
   );

   mode_alu4_subtractor_chain #(.WIDTH(WIDTH)) u_sub (
      .x_i(sub_x), .y_i(sub_y), .bin_i(sub_rt.in_bit),
      .diff_o(sub_d), .bout_o(sub_b)
   );

   mode_alu4_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .a_i(op_a), .b_i(op_b), .code_i(code), .f_o(logic_f)
   );

   // output selector; pass-through codes never raise the flag
   always_comb begin
      unique case (src)
         SRC_LOGIC: begin f_next = logic_f; c_next = 1'b0; end
         SRC_ADD:   begin f_next = add_s;   c_next = add_c; end
         SRC_SUB:   begin f_next = sub_d;   c_next = sub_b; end
         default:   begin f_next = '0;      c_next = 1'b0; end
      endcase
   end

   mode_alu4_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .f_i(f_next), .c_i(c_next),
      .f_o(result), .c_o(carry_out)
   );
endmodule

// File: rtl/mode_alu4_chk.sv
module mode_alu4_chk #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             mode_logic,
   input logic [3:0]       func_sel,
   input logic [WIDTH-1:0] result,
   input logic             carry_out
);
   logic [WIDTH-1:0] d_a, d_b;
   logic             d_m, seen;
   logic [3:0]       d_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_a <= '0; d_b <= '0; d_m <= 1'b0; d_s <= '0; seen <= 1'b0;
      end else begin
         d_a <= op_a; d_b <= op_b; d_m <= mode_logic; d_s <= func_sel; seen <= 1'b1;
      end
   end

   logic [WIDTH-1:0] e_a, e_b;
   logic             e_m, ok;
   logic [3:0]       e_s;

   if (REG_OUT) begin : g_lat
      assign e_a = d_a; assign e_b = d_b; assign e_m = d_m; assign e_s = d_s;
      assign ok  = seen;
   end else begin : g_now
      assign e_a = op_a; assign e_b = op_b; assign e_m = mode_logic; assign e_s = func_sel;
      assign ok  = 1'b1;
   end

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ok && e_s[3] |-> result == '0 && !carry_out); // R7
   AST_LOGIC_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ok && e_m |-> !carry_out); // R1
   AST_XOR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      ok && e_m && e_s == 4'b0111 |-> result == (e_a ^ e_b)); // R1
   AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !e_m && e_s == 4'b0000 |-> result == e_a && !carry_out); // R2
   AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !e_m && e_s == 4'b0100 && e_a == '1 |-> result == '0 && carry_out); // R5
   AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !e_m && e_s == 4'b0101 && e_a == '0 |-> result == '1 && carry_out); // R6
   AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !e_m && e_s == 4'b0011 |-> carry_out == (e_a < e_b)); // R4
endmodule

bind mode_alu4 mode_alu4_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
   .mode_logic(mode_logic), .func_sel(func_sel),
   .result(result), .carry_out(carry_out)
);

// File: tb/mode_alu4_tb.sv
module mode_alu4_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_a = '0, op_b = '0, func_sel = '0;
   logic       mode_logic = 1'b0;
   logic [3:0] result;
   logic       carry_out;

   int n_run = 0, n_fail = 0;
   bit reported = 0;

   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   mode_alu4 u_dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .mode_logic(mode_logic), .func_sel(func_sel),
      .result(result), .carry_out(carry_out)
   );

   function automatic string req_tag(input logic m, input logic [3:0] s);
      if (s[3]) return "R7";
      if (m) return (s == 4'd5 || s == 4'd6) ? "R2" : "R1";
      case (s)
         4'd0, 4'd1: return "R2";
         4'd2:       return "R3";
         4'd3:       return "R4";
         4'd4, 4'd6: return "R5";
         default:    return "R6";
      endcase
   endfunction

   // behavioural reference: {flag, result}
   function automatic logic [4:0] model(input logic m, input logic [3:0] s,
                                        input logic [3:0] a, input logic [3:0] b);
      int ia = a, ib = b, r = 0, fl = 0;
      if (s[3]) return 5'd0;
      if (m) begin
         case (s)
            4'd0: r = ~ia; 4'd1: r = ~ib; 4'd2: r = ia & ib; 4'd3: r = ia | ib;
            4'd4: r = ~(ia & ib); 4'd5: r = ia; 4'd6: r = ib; default: r = ia ^ ib;
         endcase
      end else begin
         case (s)
            4'd0: r = ia;
            4'd1: r = ib;
            4'd2: begin r = ia + ib; fl = (r > 15); end
            4'd3: begin r = ia - ib; fl = (ia < ib); end
            4'd4: begin r = ia + 1;  fl = (ia == 15); end
            4'd5: begin r = ia - 1;  fl = (ia == 0); end
            4'd6: begin r = ib + 1;  fl = (ib == 15); end
            default: begin r = ib - 1; fl = (ib == 0); end
         endcase
      end
      return {fl[0], r[3:0]};
   endfunction

   task automatic compare(input logic [4:0] exp, input string tag);
      n_run++;
      if ({carry_out, result} !== exp) begin
         n_fail++;
         $display("FAIL %s: got flag=%0b f=%h, expected flag=%0b f=%h",
                  tag, carry_out, result, exp[4], exp[3:0]);
      end
   endtask

   task automatic check_pending();
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
   endtask

   task automatic step(input logic m, input logic [3:0] s,
                       input logic [3:0] a, input logic [3:0] b);
      @(negedge clk);
      check_pending();
      mode_logic = m; func_sel = s; op_a = a; op_b = b;
      exp_q.push_back(model(m, s, a, b));
      tag_q.push_back(req_tag(m, s));
   endtask

   task automatic finish_run();
      if (!reported) begin
         reported = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      finish_run();
   end

   initial begin
      // R8: reset clears the registered outputs despite live inputs
      op_a = 4'hF; op_b = 4'hF; func_sel = 4'd2; mode_logic = 1'b0;
      repeat (3) @(negedge clk);
      compare(5'd0, "R8");
      rst_n = 1'b1;
      // every operand pair, every code, both modes; one-cycle latency is R8
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 16; s++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++)
                  step(m[0], s[3:0], a[3:0], b[3:0]);
      @(negedge clk);
      check_pending();
      finish_run();
   end
endmodule